// File: doc/BRIEF.md
# Bank Activate Timing Guard

This block stands between a memory controller's command scheduler and an eight-bank DDR2-style command bus. Each clock it receives at most one decoded command: an activate, read, write, precharge of a single bank, precharge of all banks, or nothing. It answers in the same cycle with an allow or a stall. Only activates can stall. An activate is held back while any of these rules is still unmet:

- the row-cycle spacing for that bank,
- the activate-to-activate spacing across banks,
- the rolling limit of four activates per window,
- the precharge recovery time of the target bank, including the longer recovery that follows a precharge of all banks.

The guard also refuses to open a bank that is already open.

When an activate is stalled, the guard records nothing. The scheduler keeps the command and offers it again on a later clock. In monitor mode the guard never stalls anything. It lets every command through and raises a one-clock violation flag after any activate that broke a rule. That activate still counts as issued.

All spacings are given in clocks and are held in registers. A new set of values is captured only on a clock where no command is offered. Reset clears every history counter and closes every bank, so the first activate is allowed at once.

Top module: `ddr_act_guard`

## Requirements
- R1: After reset every bank is closed and all history is clear. An activate to any bank is allowed in the first cycle, and `violation` is low.
- R2: After an activate to a bank is issued at clock edge N, another activate to the same bank is stalled before edge N+tRC and may be issued from edge N+tRC on.
- R3: After any activate is issued at edge N, an activate to a different bank is stalled before edge N+tRRD.
- R4: At most four activates are issued in any tFAW consecutive clock edges. With a window of 10, after four activates the earliest of which was at edge N, the next activate is stalled until edge N+10.
- R5: An activate to a bank that is open is stalled. A single-bank precharge issued at edge N closes that bank, and its next activate may be issued no earlier than edge N+tRP.
- R6: A precharge-all issued at edge N closes all banks, and no bank may be activated before edge N+tRP+1.
- R7: The opcode encoding is 0 no-op, 1 activate, 2 read, 3 write, 4 precharge one bank, 5 precharge all. Opcodes other than 1 are never stalled (`cmd_allow`=1, `cmd_stall`=0). Reads and writes change no timing state.
- R8: A stalled activate leaves no trace. It changes no bank, spacing or window state.
- R9: With `monitor_only` high, no command is stalled. An activate that breaks any rule is counted as issued, and `violation` is high for exactly the cycle after its edge. An activate that breaks no rule leaves `violation` low.
- R10: The four timing values are captured when `cfg_load` is high and `cmd_valid` is low. A load request made while `cmd_valid` is high is ignored. A timing value of 0 or 1 permits commands on consecutive edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are taken at the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Capture the timing values (only while `cmd_valid` is low) |
| cfg_trc | input | TW | Row-cycle spacing, same bank, clocks |
| cfg_trrd | input | TW | Activate spacing across banks, clocks |
| cfg_tfaw | input | TW | Rolling four-activate window, clocks |
| cfg_trp | input | TW | Single-bank precharge recovery, clocks |
| monitor_only | input | 1 | Pass everything, flag rule breaks instead |
| cmd_valid | input | 1 | A command is offered this cycle |
| cmd_op | input | 3 | Opcode (encoding in R7) |
| cmd_bank | input | BW | Target bank |
| cmd_allow | output | 1 | Offered command may be issued at the coming edge |
| cmd_stall | output | 1 | Offered activate is held back |
| violation | output | 1 | One-clock pulse after a rule-breaking activate in monitor mode |

## Verification
The spacing assertion compares the gap since the previous issued activate against the current tRRD register. It therefore assumes the timing values are not raised while an earlier activate's spacing is still running. The bench keeps to this by loading new values only after several idle clocks. The assertions also assume `cmd_op` carries one of the six defined codes. They assume the inputs are quiet (`cmd_valid` low) during reset, and the bench drives every input to a defined value from time zero. The stimulus table is laid out so that, wherever possible, each expected stall has exactly one unmet rule. That way a single broken counter shows up as a single wrong row.

// File: rtl/ddr_guard_pkg.sv
package ddr_guard_pkg;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_ACT  = 3'd1,
        OP_RD   = 3'd2,
        OP_WR   = 3'd3,
        OP_PRE  = 3'd4,
        OP_PREA = 3'd5
    } cmd_op_e;

endpackage

// File: rtl/ddr_spacing_timer.sv
module ddr_spacing_timer #(
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] span_i,
    output logic          idle_o
);

    typedef struct packed {
        logic [TW-1:0] cnt;
    } spc_st_t;

    spc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - TW'(1);
        end
        if (load_i) begin
            st_d.cnt = (span_i == '0) ? '0 : span_i - TW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idle_o = (st_q.cnt == '0);

endmodule

// File: rtl/ddr_bank_timer.sv
module ddr_bank_timer #(
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act_i,
    input  logic          pre_i,
    input  logic          prea_i,
    input  logic [TW-1:0] trc_i,
    input  logic [TW-1:0] trp_i,
    output logic          ready_o,
    output logic          open_o
);

    typedef struct packed {
        logic          open;
        logic [TW-1:0] trc;
        logic [TW-1:0] rp;
    } bank_st_t;

    bank_st_t st_d, st_q;

    function automatic logic [TW-1:0] dec_sat(input logic [TW-1:0] v);
        return (v == '0) ? v : v - TW'(1);
    endfunction

    function automatic logic [TW-1:0] first_val(input logic [TW-1:0] t);
        return (t == '0) ? '0 : t - TW'(1);
    endfunction

    always_comb begin
        st_d     = st_q;
        st_d.trc = dec_sat(st_q.trc);
        st_d.rp  = dec_sat(st_q.rp);
        if (act_i) begin
            st_d.open = 1'b1;
            st_d.trc  = first_val(trc_i);
        end
        if (pre_i) begin
            st_d.open = 1'b0;
            st_d.rp   = first_val(trp_i);
        end
        if (prea_i) begin
            st_d.open = 1'b0;
            st_d.rp   = trp_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready_o = !st_q.open && (st_q.trc == '0) && (st_q.rp == '0);
    assign open_o  = st_q.open;

endmodule

// File: rtl/ddr_faw_window.sv
module ddr_faw_window #(
    parameter int TW    = 6,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act_i,
    input  logic [TW-1:0] tfaw_i,
    output logic          ready_o
);

    typedef struct packed {
        logic [DEPTH-1:0][TW-1:0] slot;
    } faw_st_t;

    faw_st_t st_d, st_q;

    function automatic logic [TW-1:0] dec_sat(input logic [TW-1:0] v);
        return (v == '0) ? v : v - TW'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < DEPTH; i++) begin
            st_d.slot[i] = dec_sat(st_q.slot[i]);
        end
        if (act_i) begin
            st_d.slot[0] = (tfaw_i == '0) ? '0 : tfaw_i - TW'(1);
            for (int i = 1; i < DEPTH; i++) begin
                st_d.slot[i] = dec_sat(st_q.slot[i-1]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready_o = (st_q.slot[DEPTH-1] == '0);

endmodule

// File: rtl/ddr_act_guard.sv
module ddr_act_guard
    import ddr_guard_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int TW        = 6,
    parameter int FAW_DEPTH = 4,
    parameter int DEF_TRC   = 4,
    parameter int DEF_TRRD  = 2,
    parameter int DEF_TFAW  = 8,
    parameter int DEF_TRP   = 2,
    localparam int BW       = $clog2(NUM_BANKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_load,
    input  logic [TW-1:0] cfg_trc,
    input  logic [TW-1:0] cfg_trrd,
    input  logic [TW-1:0] cfg_tfaw,
    input  logic [TW-1:0] cfg_trp,
    input  logic          monitor_only,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [BW-1:0] cmd_bank,
    output logic          cmd_allow,
    output logic          cmd_stall,
    output logic          violation
);

    typedef struct packed {
        logic [TW-1:0] trc;
        logic [TW-1:0] trrd;
        logic [TW-1:0] tfaw;
        logic [TW-1:0] trp;
    } timing_cfg_t;

    typedef struct packed {
        timing_cfg_t cfg;
        logic        viol;
    } guard_st_t;

    guard_st_t st_d, st_q;
    timing_cfg_t cfg_q;

    cmd_op_e              op;
    logic                 is_act;
    logic                 rules_ok;
    logic                 act_go;
    logic                 pre_go;
    logic                 prea_go;
    logic                 rrd_idle;
    logic                 faw_ready;
    logic [NUM_BANKS-1:0] bank_ready;
    logic [NUM_BANKS-1:0] bank_open;
    logic [NUM_BANKS-1:0] bank_act;
    logic [NUM_BANKS-1:0] bank_pre;

    assign cfg_q   = st_q.cfg;
    assign op      = cmd_op_e'(cmd_op);
    assign is_act  = cmd_valid && (op == OP_ACT);
    assign pre_go  = cmd_valid && (op == OP_PRE);
    assign prea_go = cmd_valid && (op == OP_PREA);

    assign rules_ok  = bank_ready[cmd_bank] && rrd_idle && faw_ready;
    assign cmd_allow = !is_act || rules_ok || monitor_only;
    assign cmd_stall = is_act && !cmd_allow;
    assign act_go    = is_act && cmd_allow;

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            assign bank_act[b] = act_go && (cmd_bank == BW'(b));
            assign bank_pre[b] = pre_go && (cmd_bank == BW'(b));

            ddr_bank_timer #(.TW(TW)) u_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .act_i   (bank_act[b]),
                .pre_i   (bank_pre[b]),
                .prea_i  (prea_go),
                .trc_i   (cfg_q.trc),
                .trp_i   (cfg_q.trp),
                .ready_o (bank_ready[b]),
                .open_o  (bank_open[b])
            );
        end
    endgenerate

    ddr_spacing_timer #(.TW(TW)) u_rrd (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (act_go),
        .span_i (cfg_q.trrd),
        .idle_o (rrd_idle)
    );

    ddr_faw_window #(.TW(TW), .DEPTH(FAW_DEPTH)) u_faw (
        .clk     (clk),
        .rst_n   (rst_n),
        .act_i   (act_go),
        .tfaw_i  (cfg_q.tfaw),
        .ready_o (faw_ready)
    );

    always_comb begin
        st_d      = st_q;
        st_d.viol = is_act && monitor_only && !rules_ok;
        if (cfg_load && !cmd_valid) begin
            st_d.cfg.trc  = cfg_trc;
            st_d.cfg.trrd = cfg_trrd;
            st_d.cfg.tfaw = cfg_tfaw;
            st_d.cfg.trp  = cfg_trp;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cfg.trc  <= TW'(DEF_TRC);
            st_q.cfg.trrd <= TW'(DEF_TRRD);
            st_q.cfg.tfaw <= TW'(DEF_TFAW);
            st_q.cfg.trp  <= TW'(DEF_TRP);
            st_q.viol     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign violation = st_q.viol;

endmodule

// File: rtl/ddr_act_guard_chk.sv
module ddr_act_guard_chk #(
    parameter int NUM_BANKS = 8,
    parameter int TW        = 6,
    localparam int BW       = $clog2(NUM_BANKS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 monitor_only,
    input logic                 cmd_valid,
    input logic [2:0]           cmd_op,
    input logic [BW-1:0]        cmd_bank,
    input logic                 cmd_allow,
    input logic                 cmd_stall,
    input logic                 violation,
    input logic [TW-1:0]        cfg_trrd,
    input logic [NUM_BANKS-1:0] bank_open
);

    logic          issued;
    logic [TW:0]   gap_q;

    assign issued = cmd_valid && (cmd_op == 3'd1) && cmd_allow;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '1;
        end else if (issued) begin
            gap_q <= (TW+1)'(1);
        end else if (gap_q != '1) begin
            gap_q <= gap_q + (TW+1)'(1);
        end
    end

    // R7: only activates are ever held back
    p_stall_act_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stall |-> (cmd_valid && cmd_op == 3'd1));

    // R9: monitor mode passes everything
    p_mon_no_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        monitor_only |-> !cmd_stall);

    // R9: a violation pulse follows a monitored activate
    p_viol_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        violation |-> $past(monitor_only && cmd_valid && cmd_op == 3'd1));

    // R3: enforced activates keep the cross-bank spacing
    p_rrd_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (issued && !monitor_only) |-> (gap_q >= {1'b0, cfg_trrd}));

    // R5: an enforced activate never targets an open bank
    p_open_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (issued && !monitor_only) |-> !bank_open[cmd_bank]);

    // R6: precharge-all leaves every bank closed
    p_prea_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd5) |=> (bank_open == '0));

endmodule

bind ddr_act_guard ddr_act_guard_chk #(
    .NUM_BANKS (NUM_BANKS),
    .TW        (TW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .monitor_only (monitor_only),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .cmd_bank     (cmd_bank),
    .cmd_allow    (cmd_allow),
    .cmd_stall    (cmd_stall),
    .violation    (violation),
    .cfg_trrd     (cfg_q.trrd),
    .bank_open    (bank_open)
);

// File: tb/ddr_act_guard_tb.sv
`timescale 1ns/1ps
module ddr_act_guard_tb;

    localparam int TW = 6;
    localparam int NROWS = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_load = 1'b0;
    logic [TW-1:0] cfg_trc = '0;
    logic [TW-1:0] cfg_trrd = '0;
    logic [TW-1:0] cfg_tfaw = '0;
    logic [TW-1:0] cfg_trp = '0;
    logic          monitor_only = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [2:0]    cmd_bank = '0;
    logic          cmd_allow;
    logic          cmd_stall;
    logic          violation;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    ddr_act_guard u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_load     (cfg_load),
        .cfg_trc      (cfg_trc),
        .cfg_trrd     (cfg_trrd),
        .cfg_tfaw     (cfg_tfaw),
        .cfg_trp      (cfg_trp),
        .monitor_only (monitor_only),
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_op),
        .cmd_bank     (cmd_bank),
        .cmd_allow    (cmd_allow),
        .cmd_stall    (cmd_stall),
        .violation    (violation)
    );

    // row: {mon, op[2:0], bank[2:0], valid, exp_allow, exp_viol}
    function automatic logic [9:0] mk(input logic m, input logic [2:0] o,
                                      input logic [2:0] b, input logic v,
                                      input logic a, input logic x);
        return {m, o, b, v, a, x};
    endfunction

    // config for the table: tRC=6 tRRD=2 tFAW=10 tRP=3
    localparam logic [9:0] ROWS [NROWS] = '{
        mk(0,1,0,1,1,0), mk(0,1,1,1,0,0), mk(0,1,1,1,1,0), mk(0,2,0,1,1,0),
        mk(0,1,2,1,1,0), mk(0,0,0,0,1,0), mk(0,1,3,1,1,0), mk(0,0,0,0,1,0),
        mk(0,1,4,1,0,0), mk(0,1,4,1,0,0), mk(0,1,4,1,1,0), mk(0,1,0,1,0,0),
        mk(0,4,0,1,1,0), mk(0,1,0,1,0,0), mk(0,1,0,1,0,0), mk(0,1,0,1,1,0),
        mk(0,4,0,1,1,0), mk(0,0,0,0,1,0), mk(0,0,0,0,1,0), mk(0,1,0,1,0,0),
        mk(0,1,0,1,0,0), mk(0,1,0,1,1,0), mk(0,5,0,1,1,0), mk(0,1,5,1,0,0),
        mk(0,1,5,1,0,0), mk(0,1,5,1,0,0), mk(0,1,5,1,1,0), mk(1,1,6,1,1,1),
        mk(0,1,7,1,0,0), mk(0,1,7,1,1,0), mk(0,0,0,0,1,0), mk(1,1,1,1,1,0)
    };

    function automatic string row_tag(input int i);
        case (i)
            0:              return "R1";
            1, 29:          return "R3";
            2:              return "R8";
            3, 4, 12, 22:   return "R7";
            8, 9, 10:       return "R4";
            11, 13, 14, 15: return "R5";
            19, 20, 21:     return "R2";
            23, 24, 25, 26: return "R6";
            27, 28, 31:     return "R9";
            default:        return "R7";
        endcase
    endfunction

    task automatic step(input logic m, input logic [2:0] o, input logic [2:0] b,
                        input logic v, input logic ld, input logic ea,
                        input logic ex, input string tag);
        @(negedge clk);
        monitor_only = m;
        cmd_op       = o;
        cmd_bank     = b;
        cmd_valid    = v;
        cfg_load     = ld;
        #1;
        total++;
        if (cmd_allow !== ea || cmd_stall !== (v && o == 3'd1 && !ea)) begin
            bad++;
            $display("FAIL %s op=%0d bank=%0d allow=%0b stall=%0b expected allow=%0b",
                     tag, o, b, cmd_allow, cmd_stall, ea);
        end
        @(posedge clk);
        #1;
        total++;
        if (violation !== ex) begin
            bad++;
            $display("FAIL %s violation=%0b expected %0b", tag, violation, ex);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cmd_valid = 1'b0;
        cfg_load = 1'b0;
        monitor_only = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();

        // R1: reset state, defaults tRC=4 tRRD=2 tFAW=8 tRP=2
        #1;
        total++;
        if (violation !== 1'b0) begin
            bad++;
            $display("FAIL R1 violation=%0b expected 0", violation);
        end

        // R10: load offered with a command present is ignored
        cfg_trc = 6'd4; cfg_trrd = 6'd7; cfg_tfaw = 6'd8; cfg_trp = 6'd2;
        step(0, 3'd1, 3'd0, 1, 1, 1, 0, "R1");
        step(0, 3'd1, 3'd1, 1, 0, 0, 0, "R3");
        step(0, 3'd1, 3'd1, 1, 0, 1, 0, "R3");
        for (int k = 0; k < 4; k++) step(0, 3'd0, 3'd0, 0, 0, 1, 0, "R10");
        // R10: idle load of tRRD=5 takes effect
        cfg_trrd = 6'd5;
        step(0, 3'd0, 3'd0, 0, 1, 1, 0, "R10");
        step(0, 3'd1, 3'd2, 1, 0, 1, 0, "R10");
        step(0, 3'd1, 3'd3, 1, 0, 0, 0, "R10");
        step(0, 3'd0, 3'd0, 0, 0, 1, 0, "R10");
        step(0, 3'd0, 3'd0, 0, 0, 1, 0, "R10");
        step(0, 3'd1, 3'd3, 1, 0, 0, 0, "R10");
        step(0, 3'd1, 3'd3, 1, 0, 1, 0, "R10");

        // table run
        do_reset();
        cfg_trc = 6'd6; cfg_trrd = 6'd2; cfg_tfaw = 6'd10; cfg_trp = 6'd3;
        step(0, 3'd0, 3'd0, 0, 1, 1, 0, "R10");
        for (int i = 0; i < NROWS; i++) begin
            step(ROWS[i][9], ROWS[i][8:6], ROWS[i][5:3], ROWS[i][2], 0,
                 ROWS[i][1], ROWS[i][0], row_tag(i));
        end

        // R10: zero spacing lets activates go back to back
        do_reset();
        cfg_trc = 6'd0; cfg_trrd = 6'd0; cfg_tfaw = 6'd0; cfg_trp = 6'd0;
        step(0, 3'd0, 3'd0, 0, 1, 1, 0, "R10");
        for (int b = 0; b < 8; b++) step(0, 3'd1, 3'(b), 1, 0, 1, 0, "R10");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule